// File: doc/BRIEF.md
# DMA Audio Sample Playback Engine

This block streams 8-bit signed audio samples from memory to a pair of DAC data ports with no processor involvement. It reads bytes through a simple memory read port whose data returns one cycle after the request. It may only issue those reads while a horizontal-blanking enable input is high. Fetched bytes wait in a small FIFO. A playback stage takes them out at a fixed sample rate, drawn from a power-of-two ladder of one master-clock divider.

Software programs a buffer start and end address, a rate, stereo or mono steering, and run and loop controls through a small write port. In stereo mode, memory holds interleaved left/right byte pairs. In mono mode, every byte goes to both channels. At the end of the buffer the engine either reloads and continues, or drains and signals completion. Clearing run aborts playback and silences both outputs.

Top module: `dma_audio_engine`

## Requirements
- R1: Each sample is an 8-bit two's-complement byte (0 = neutral) copied unchanged from memory to `dac_left`/`dac_right`. Both outputs reset to 0, with `run_o`, `underrun_o`, `done_irq`, `dac_load` and `mem_req` low.
- R2: `mem_req` is never high while `hblank` is low. `mem_rdata` is taken as the byte at `mem_addr` one cycle after the request.
- R3: The control register (address 0) holds the rate in bits [4:3]: 00 = slowest, 01 = 2x, 10 = 4x, 11 = fastest. With data available, consecutive `dac_load` pulses are exactly `BASE_DIV * 2^(3-rate)` cycles apart.
- R4: Stereo is selected when control bit 2 is 0. In stereo, the byte at an even offset goes to the left output and the next byte to the right output. Both outputs change on the same `dac_load` pulse.
- R5: Mono is selected when control bit 2 is 1. In mono, each byte goes to both outputs on one `dac_load` pulse, in address order.
- R6: Fetching proceeds while `hblank` is high until the 8-byte FIFO (counting a read in flight) is full or the end address is reached. The FIFO never holds more than its depth.
- R7: At a sample tick without enough buffered bytes (1 for mono, 2 for stereo), there is no `dac_load`, the outputs hold, and the sticky `underrun_o` is set. Writing 1 to bit 0 of address 3 clears it.
- R8: The end address is exclusive. With loop (control bit 1) at 0, fetching stops at the end address and the FIFO drains. Then `run_o` falls and `done_irq` is high for exactly one cycle, after every buffered sample has been played.
- R9: With loop at 1, after the byte just below the end address, fetching restarts from the start address and playback continues without stopping.
- R10: Run is control bit 0. Writing it to 0 while running stops requests, flushes the FIFO and drives both outputs to 0 on the next edge, with no `done_irq`.
- R11: The start (address 1) and end (address 2) registers ignore bit 0 and are copied into the fetch engine only when run is set or a loop reload happens. Writes during a pass do not alter that pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 start, 2 end, 3 status |
| reg_wdata | input | ADDR_W | Register write data |
| hblank | input | 1 | Fetch window enable |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| dac_left | output | 8 | Left channel sample, signed |
| dac_right | output | 8 | Right channel sample, signed |
| dac_load | output | 1 | One-cycle pulse when the DAC outputs take a new sample |
| run_o | output | 1 | Playback active |
| underrun_o | output | 1 | Sticky starvation flag |
| done_irq | output | 1 | One-cycle pulse when a non-looping buffer finishes |

## Verification
The DAC outputs and `dac_load` change on the edge after an internal rate tick. `run_o` falls and `done_irq` pulses on the edge after the FIFO drains. An abort zeroes the outputs on the edge that takes the control write. `mem_req` follows `hblank` within the same cycle. The bench changes inputs and samples outputs on the falling edge, so every registered result has settled. Each `dac_load` is compared with the byte its position in the buffer predicts, and the spacing between loads is compared with the divider arithmetic only when blanking is held open. Status and abort results are read on the falling edge right after the write that causes them.

// File: rtl/dma_audio_pkg.sv
package dma_audio_pkg;

    typedef enum logic [1:0] {
        RATE_DIV8 = 2'b00,
        RATE_DIV4 = 2'b01,
        RATE_DIV2 = 2'b10,
        RATE_DIV1 = 2'b11
    } rate_e;

    typedef struct packed {
        logic  loop;
        logic  mono;
        rate_e rate;
    } mode_t;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_START = 2'd1;
    localparam logic [1:0] REG_END   = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;

    // Ladder bits that must all be one for a tick at the given rate.
    function automatic logic [2:0] ladder_mask(rate_e r);
        case (r)
            RATE_DIV8: return 3'b111;
            RATE_DIV4: return 3'b011;
            RATE_DIV2: return 3'b001;
            default:   return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/dmaa_rate_gen.sv
module dmaa_rate_gen
    import dma_audio_pkg::*;
#(
    parameter int BASE_DIV = 160
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  rate_e rate,
    output logic  tick
);
    localparam int CW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;

    logic [CW-1:0] pcnt_q;
    logic [2:0]    ladder_q;
    logic          base;

    assign base = (pcnt_q == CW'(BASE_DIV - 1));
    assign tick = base && ((ladder_q & ladder_mask(rate)) == ladder_mask(rate));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt_q   <= '0;
            ladder_q <= '0;
        end else if (base) begin
            pcnt_q   <= '0;
            ladder_q <= ladder_q + 3'd1;
        end else begin
            pcnt_q   <= pcnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/dmaa_fetch.sv
module dmaa_fetch #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              active,
    input  logic              loop,
    input  logic [ADDR_W-1:0] start_reg,
    input  logic [ADDR_W-1:0] end_reg,
    input  logic              hblank,
    input  logic              room,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              in_flight,
    output logic              exhausted
);
    logic [ADDR_W-1:0] addr_q, end_q, next_addr;

    assign next_addr = addr_q + ADDR_W'(1);
    assign mem_req   = active && hblank && !exhausted && room;
    assign mem_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            end_q     <= '0;
            exhausted <= 1'b1;
            in_flight <= 1'b0;
        end else if (abort) begin
            exhausted <= 1'b1;
            in_flight <= 1'b0;
        end else if (start) begin
            addr_q    <= start_reg;
            end_q     <= end_reg;
            exhausted <= (start_reg == end_reg);
            in_flight <= 1'b0;
        end else begin
            in_flight <= mem_req;
            if (mem_req) begin
                if (next_addr == end_q) begin
                    if (loop) begin
                        addr_q    <= start_reg;
                        end_q     <= end_reg;
                        exhausted <= (start_reg == end_reg);
                    end else begin
                        exhausted <= 1'b1;
                    end
                end else begin
                    addr_q <= next_addr;
                end
            end
        end
    end
endmodule

// File: rtl/dmaa_fifo.sv
module dmaa_fifo #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [1:0]       pop_n,
    output logic [7:0]       head0,
    output logic [7:0]       head1,
    output logic [CNT_W-1:0] count
);
    localparam int PW = $clog2(DEPTH);

    logic [7:0]    store_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q, rp_next1;

    assign rp_next1 = rp_q + PW'(1);
    assign head0    = store_q[rp_q];
    assign head1    = store_q[rp_next1];

    always_ff @(posedge clk) begin
        if (push) store_q[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (push) wp_q <= wp_q + PW'(1);
            rp_q  <= rp_q + PW'(pop_n);
            count <= count + CNT_W'(push) - CNT_W'(pop_n);
        end
    end
endmodule

// File: rtl/dmaa_steer.sv
module dmaa_steer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic             running,
    input  logic             mono,
    input  logic             draining_done,
    input  logic [CNT_W-1:0] count,
    input  logic [7:0]       head0,
    input  logic [7:0]       head1,
    output logic [1:0]       pop_n,
    output logic             starve,
    output logic [7:0]       left_q,
    output logic [7:0]       right_q,
    output logic             load_q
);
    logic have, play;

    assign have   = mono ? (count != '0) : (count >= CNT_W'(2));
    assign play   = running && tick && have;
    assign starve = running && tick && !have && !draining_done;
    assign pop_n  = play ? (mono ? 2'd1 : 2'd2) : 2'd0;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            left_q  <= '0;
            right_q <= '0;
            load_q  <= 1'b0;
        end else begin
            load_q <= play;
            if (play) begin
                left_q  <= head0;
                right_q <= mono ? head0 : head1;
            end
        end
    end
endmodule

// File: rtl/dma_audio_engine.sv
module dma_audio_engine
    import dma_audio_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int BASE_DIV   = 160,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              hblank,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic signed [7:0] dac_left,
    output logic signed [7:0] dac_right,
    output logic              dac_load,
    output logic              run_o,
    output logic              underrun_o,
    output logic              done_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    mode_t             mode_q;
    logic [ADDR_W-1:0] start_q, end_q;
    logic              running_q, underrun_q, done_q;
    logic              ctrl_wr, start_go, abort, stat_clr;
    logic              tick, room, in_flight, exhausted, drain_stop, starve;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [7:0]        head0, head1, left_q, right_q;
    logic [1:0]        pop_n;

    assign ctrl_wr    = reg_we && (reg_addr == REG_CTRL);
    assign start_go   = ctrl_wr && reg_wdata[0] && !running_q;
    assign abort      = ctrl_wr && !reg_wdata[0] && running_q;
    assign stat_clr   = reg_we && (reg_addr == REG_STAT) && reg_wdata[0];
    assign room       = (fifo_cnt + CNT_W'(in_flight)) < CNT_W'(FIFO_DEPTH);
    assign drain_stop = running_q && exhausted && !in_flight && (fifo_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            start_q    <= '0;
            end_q      <= '0;
            running_q  <= 1'b0;
            underrun_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (ctrl_wr)
                mode_q <= '{loop: reg_wdata[1], mono: reg_wdata[2], rate: rate_e'(reg_wdata[4:3])};
            if (reg_we && reg_addr == REG_START) start_q <= {reg_wdata[ADDR_W-1:1], 1'b0};
            if (reg_we && reg_addr == REG_END)   end_q   <= {reg_wdata[ADDR_W-1:1], 1'b0};
            if (start_go)                     running_q <= 1'b1;
            else if (abort || drain_stop)     running_q <= 1'b0;
            if (starve)        underrun_q <= 1'b1;
            else if (stat_clr) underrun_q <= 1'b0;
            done_q <= drain_stop;
        end
    end

    dmaa_rate_gen #(.BASE_DIV(BASE_DIV)) rate_i (
        .clk(clk), .rst(rst), .restart(start_go), .rate(mode_q.rate), .tick(tick)
    );

    dmaa_fetch #(.ADDR_W(ADDR_W)) fetch_i (
        .clk(clk), .rst(rst), .start(start_go), .abort(abort), .active(running_q),
        .loop(mode_q.loop), .start_reg(start_q), .end_reg(end_q), .hblank(hblank),
        .room(room), .mem_req(mem_req), .mem_addr(mem_addr),
        .in_flight(in_flight), .exhausted(exhausted)
    );

    dmaa_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) fifo_i (
        .clk(clk), .rst(rst), .flush(abort || start_go), .push(in_flight),
        .din(mem_rdata), .pop_n(pop_n), .head0(head0), .head1(head1), .count(fifo_cnt)
    );

    dmaa_steer #(.CNT_W(CNT_W)) steer_i (
        .clk(clk), .rst(rst), .clear(abort), .tick(tick), .running(running_q),
        .mono(mode_q.mono), .draining_done(drain_stop), .count(fifo_cnt),
        .head0(head0), .head1(head1), .pop_n(pop_n), .starve(starve),
        .left_q(left_q), .right_q(right_q), .load_q(dac_load)
    );

    assign dac_left   = left_q;
    assign dac_right  = right_q;
    assign run_o      = running_q;
    assign underrun_o = underrun_q;
    assign done_irq   = done_q;
endmodule

// File: rtl/dma_audio_engine_chk.sv
module dma_audio_engine_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             hblank,
    input logic             mem_req,
    input logic             dac_load,
    input logic             run_o,
    input logic             done_irq,
    input logic             mono_q,
    input logic [7:0]       dac_left,
    input logic [7:0]       dac_right,
    input logic [CNT_W-1:0] fifo_cnt
);
    p_blank_only_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> hblank);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    p_mono_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (dac_load && $past(mono_q)) |-> (dac_left == dac_right));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (run_o && $past(run_o) && !dac_load) |-> ($stable(dac_left) && $stable(dac_right)));

    p_done_stops_r8: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> !run_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    p_abort_silence_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_o) && !done_irq) |-> (dac_left == 8'd0 && dac_right == 8'd0));
endmodule

bind dma_audio_engine dma_audio_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .hblank(hblank), .mem_req(mem_req), .dac_load(dac_load),
    .run_o(run_o), .done_irq(done_irq), .mono_q(mode_q.mono),
    .dac_left(dac_left), .dac_right(dac_right), .fifo_cnt(fifo_cnt)
);

// File: tb/dma_audio_engine_tb_top.sv
module dma_audio_engine_tb_top;
    localparam int AW  = 16;
    localparam int BD  = 8;
    localparam int DEP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic          hblank;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = '0;
    logic signed [7:0] dac_left, dac_right;
    logic          dac_load, run_o, underrun_o, done_irq;

    int vec = 0, bad = 0, cyc = 0, hb_mode = 0;
    int s0, e0, s1, e1, k = 0, last_ld = 0, period = 0, done_cnt = 0;
    bit mono_e = 0, chk_int = 0, prev_done = 0, finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign hblank = (hb_mode == 0) || (hb_mode == 1 && (cyc % 32) < 12);

    dma_audio_engine #(.ADDR_W(AW), .BASE_DIV(BD), .FIFO_DEPTH(DEP)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .hblank(hblank), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dac_left(dac_left), .dac_right(dac_right), .dac_load(dac_load),
        .run_o(run_o), .underrun_o(underrun_o), .done_irq(done_irq)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(((a * 37) + 11) ^ (a >> 8));
    endfunction

    function automatic int exp_addr(int b);
        if (b < e0 - s0) return s0 + b;
        return s1 + ((b - (e0 - s0)) % (e1 - s1));
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(posedge clk) if (mem_req) mem_rdata <= pat(int'(mem_addr));

    // Monitor: every load compared with the byte its position predicts.
    always @(negedge clk) begin
        if (!rst) begin
            if (done_irq && prev_done) check(1'b0, "R8 done width", 2, 1);
            if (done_irq) done_cnt++;
            prev_done = done_irq;
            if (dac_load) begin
                int b;
                logic [7:0] el, er;
                b  = mono_e ? k : 2 * k;
                el = pat(exp_addr(b));
                er = mono_e ? el : pat(exp_addr(b + 1));
                check(8'(dac_left) == el, mono_e ? "R5 R1 left" : "R4 R1 left", int'(8'(dac_left)), int'(el));
                check(8'(dac_right) == er, mono_e ? "R5 R1 right" : "R4 R1 right", int'(8'(dac_right)), int'(er));
                if (chk_int && k > 0) check(cyc - last_ld == period, "R3 spacing", cyc - last_ld, period);
                last_ld = cyc;
                k++;
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = AW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic int ctrl(int run, int loop, int mono, int rate);
        return run | (loop << 1) | (mono << 2) | (rate << 3);
    endfunction

    task automatic prep(int rate, bit mono, int st, int en, int st2, int en2, int hbm);
        wr(3, 1);
        hb_mode = hbm;
        s0 = st & ~1; e0 = en & ~1; s1 = st2 & ~1; e1 = en2 & ~1;
        mono_e = mono; k = 0; chk_int = (hbm == 0);
        period = BD << (3 - rate);
        wr(1, st); wr(2, en);
    endtask

    task automatic run_once(int rate, bit mono, int st, int en, int hbm);
        int d0, waitc;
        prep(rate, mono, st, en, st, en, hbm);
        d0 = done_cnt;
        wr(0, ctrl(1, 0, mono, rate));
        waitc = 0;
        while (done_cnt == d0 && waitc < 20000) begin @(negedge clk); waitc++; end
        check(done_cnt == d0 + 1, "R8 done seen", done_cnt - d0, 1);
        check(run_o == 1'b0, "R8 run cleared", int'(run_o), 0);
        check(k == (e0 - s0) / (mono ? 1 : 2), "R8 all samples played", k, (e0 - s0) / (mono ? 1 : 2));
        if (hbm == 0) check(underrun_o == 1'b0, "R7 no underrun", int'(underrun_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dac_left == 0 && dac_right == 0, "R1 reset outputs", int'(dac_left), 0);
        check(!run_o && !underrun_o && !done_irq && !dac_load, "R1 reset flags", int'(run_o), 0);
        check(!mem_req, "R1 reset request", int'(mem_req), 0);

        // Sweep every rate in both steering modes, blanking held open.
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 2; m++)
                run_once(r, m[0], 16'h0040 + 16 * (4 * r + m) * 2, 16'h0040 + 16 * (4 * r + m) * 2 + 12, 0);

        // Odd register values are treated as even (R11).
        run_once(3, 1'b0, 16'h0131, 16'h0141, 0);

        // Narrow blanking windows: order is kept, no request outside (R2, R6).
        run_once(2, 1'b0, 16'h0200, 16'h0218, 1);
        run_once(1, 1'b1, 16'h0300, 16'h0310, 1);
        run_once(3, 1'b1, 16'h0340, 16'h0360, 1);

        // Loop with register rewrite during the first pass (R9, R11), then abort (R10).
        for (int m = 0; m < 2; m++) begin
            int d0;
            prep(3, m[0], 16'h0400, 16'h0410, 16'h0500, 16'h0506, 0);
            d0 = done_cnt;
            wr(0, ctrl(1, 1, m, 3));
            wr(1, 16'h0500); wr(2, 16'h0506);
            while (k < 30) @(negedge clk);
            wr(0, ctrl(0, 1, m, 3));
            check(dac_left == 0 && dac_right == 0, "R10 outputs zeroed", int'(dac_left), 0);
            check(run_o == 1'b0, "R10 run cleared", int'(run_o), 0);
            check(done_cnt == d0, "R10 no done on abort", done_cnt - d0, 0);
            begin
                int reqs = 0;
                repeat (20) begin @(negedge clk); if (mem_req) reqs++; end
                check(reqs == 0, "R10 fetch stopped", reqs, 0);
            end
            check(k == 30, "R9 loop kept playing", k, 30);
        end

        // Starvation: blanking closed, no samples arrive (R7).
        begin
            prep(3, 1'b1, 16'h0600, 16'h0610, 16'h0600, 16'h0610, 2);
            wr(0, ctrl(1, 0, 1, 3));
            repeat (60) @(negedge clk);
            check(underrun_o == 1'b1, "R7 underrun set", int'(underrun_o), 1);
            check(k == 0, "R7 no load while starved", k, 0);
            check(dac_left == 0 && dac_right == 0, "R7 outputs held", int'(dac_left), 0);
            check(run_o == 1'b1, "R7 still running", int'(run_o), 1);
            wr(0, ctrl(0, 0, 1, 3));
            check(underrun_o == 1'b1, "R7 flag sticky", int'(underrun_o), 1);
            wr(3, 1);
            check(underrun_o == 1'b0, "R7 flag cleared", int'(underrun_o), 0);
        end

        // Empty buffer finishes at once (R8).
        run_once(3, 1'b0, 16'h0700, 16'h0700, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vec++; bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule